// File: doc/BRIEF.md
# Six-State Counter with Unused-Code Recovery

This block is a synchronous three-bit counter that steps through a fixed cycle of six codes instead of a plain binary count. The top bit (called A) changes once every three counts. The two low bits (B, C) step through 00, 01, 10 within each group of three. The next-state logic is made of three J-K stages: A toggles when B is 1, B takes the value of C&~B, and C takes the value of ~B&~C.

Two of the eight codes, 011 and 111, are not part of the cycle. The logic is shaped so that either of them falls back into the cycle on the next enabled edge. A flag output reports, in the same cycle, when the register holds one of these codes.

A load input writes any three-bit code into the register. It is mainly there so that the recovery paths can be checked directly. The counter is meant for stepping through a repeating six-phase schedule where a disturbed state must not lock up the sequence.

Top module: `sixstate_counter`

## Requirements
- R1: With `en` high and no reset or load, `count_q` (bit 2 = A, bit 1 = B, bit 0 = C) follows 000, 001, 010, 100, 101, 110 and then returns to 000, one step per rising clock edge.
- R2: `rst` high at a rising edge sets `count_q` to 000 at that edge. It takes priority over `load` and `en`.
- R3: With `rst` and `load` low and `en` low, `count_q` keeps its value across the edge.
- R4: With `rst` low and `load` high, `count_q` takes the value of `load_code` at the edge, whatever the value of `en`.
- R5: `unused` is 1 exactly when `count_q` is 011 or 111, and 0 for the other six codes. It follows `count_q` with no added register delay.
- R6: From 011 an enabled step gives 100. From 111 an enabled step gives 000.
- R7: On an enabled step where B is 1, A is inverted and C becomes 0.
- R8: On an enabled step where C is 1, B is inverted. Where C is 0, B becomes 0.
- R9: From any of the six cycle codes, an enabled step never lands on 011 or 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable, active high |
| load | input | 1 | Loads `load_code` at the next edge, active high |
| load_code | input | 3 | Code to write when `load` is high |
| count_q | output | 3 | Present state {A, B, C} |
| unused | output | 1 | High when `count_q` is an unused code |

## Verification
The assertions assume that `rst`, `en`, `load` and `load_code` are stable around each rising edge. They also assume that every clocked check starts only after reset has been seen. The bench changes inputs only on falling edges and asserts reset from time zero, so both assumptions hold. The pseudo-random phase mixes enable, load and reset so that both unused codes are loaded often and then released with `en` both high and low. This keeps the input combinations inside the priority order that the properties take for granted.

// File: rtl/sixstate_pkg.sv
package sixstate_pkg;
  localparam int CW    = 3;
  localparam int BIT_A = 2;
  localparam int BIT_B = 1;
  localparam int BIT_C = 0;

  typedef logic [CW-1:0] code_t;

  // J-K stage: set on J only, clear on K only, toggle on both, hold on neither
  function automatic logic jk_next(input logic q, input logic j, input logic k);
    return (j & ~q) | (~k & q);
  endfunction

  // codes outside the six-step cycle have both low bits set
  function automatic logic code_is_unused(input code_t c);
    return c[BIT_B] & c[BIT_C];
  endfunction
endpackage

// File: rtl/sixstate_next.sv
module sixstate_next
  import sixstate_pkg::*;
(
  input  code_t cur,
  output code_t nxt
);
  logic [CW-1:0] j_in;
  logic [CW-1:0] k_in;

  always_comb begin
    j_in[BIT_A] = cur[BIT_B];
    k_in[BIT_A] = cur[BIT_B];
    j_in[BIT_B] = cur[BIT_C];
    k_in[BIT_B] = 1'b1;
    j_in[BIT_C] = ~cur[BIT_B];
    k_in[BIT_C] = 1'b1;
  end

  for (genvar i = 0; i < CW; i++) begin : g_stage
    assign nxt[i] = jk_next(cur[i], j_in[i], k_in[i]);
  end
endmodule

// File: rtl/sixstate_reg.sv
module sixstate_reg
  import sixstate_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  step,
  input  logic  wr,
  input  code_t wr_code,
  input  code_t nxt,
  output code_t q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (wr)   q <= wr_code;
    else if (step) q <= nxt;
  end

  // R3: idle edge keeps the state
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!wr && !step) |=> $stable(q));

  // R4: a load writes the supplied code
  p_load_takes_r4: assert property (@(posedge clk) disable iff (rst)
    wr |=> (q == $past(wr_code)));
endmodule

// File: rtl/sixstate_flag.sv
module sixstate_flag
  import sixstate_pkg::*;
(
  input  code_t cur,
  output logic  bad_code
);
  assign bad_code = code_is_unused(cur);
endmodule

// File: rtl/sixstate_counter.sv
module sixstate_counter
  import sixstate_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          load,
  input  logic [CW-1:0] load_code,
  output logic [CW-1:0] count_q,
  output logic          unused
);
  code_t cur;
  code_t nxt;
  logic  adv;     // an ordinary enabled step happens at this edge

  assign adv = en & ~load;

  sixstate_next u_next (.cur(cur), .nxt(nxt));

  sixstate_reg u_reg (
    .clk(clk), .rst(rst), .step(en), .wr(load),
    .wr_code(load_code), .nxt(nxt), .q(cur)
  );

  sixstate_flag u_flag (.cur(cur), .bad_code(unused));

  assign count_q = cur;

  // R6: an unused code leaves the unused set on the next step
  p_recover_r6: assert property (@(posedge clk) disable iff (rst)
    (adv && unused) |=> !unused);

  // R9: the cycle is closed
  p_cycle_closed_r9: assert property (@(posedge clk) disable iff (rst)
    (adv && !unused) |=> !unused);

  // R7: B set means A flips and C clears
  p_b_flips_a_r7: assert property (@(posedge clk) disable iff (rst)
    (adv && cur[BIT_B]) |=> (cur[BIT_A] != $past(cur[BIT_A])) && !cur[BIT_C]);

  // R8: C set means B flips
  p_c_flips_b_r8: assert property (@(posedge clk) disable iff (rst)
    (adv && cur[BIT_C]) |=> (cur[BIT_B] != $past(cur[BIT_B])));
endmodule

// File: tb/sixstate_counter_bench.sv
`timescale 1ns/100ps
module sixstate_counter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       load = 1'b0;
  logic [2:0] load_code = 3'b000;
  logic [2:0] count_q;
  logic       unused;

  int checks = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;
  logic [2:0] model = 3'b000;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  sixstate_counter u_sixstate_counter (
    .clk(clk), .rst(rst), .en(en), .load(load),
    .load_code(load_code), .count_q(count_q), .unused(unused)
  );

  // position in the six-step schedule: group (0/1) times three plus phase
  function automatic int pos_of(input logic [2:0] c);
    int ph;
    ph = c[1] ? 2 : (c[0] ? 1 : 0);
    return (c[2] ? 3 : 0) + ph;
  endfunction

  function automatic logic [2:0] code_at(input int p);
    int g;
    int ph;
    g = p / 3;
    ph = p % 3;
    return {g == 1, ph == 2, ph == 1};
  endfunction

  function automatic logic [2:0] model_next(input logic [2:0] c);
    if (c == 3'd3) return code_at(3);
    if (c == 3'd7) return code_at(0);
    return code_at((pos_of(c) + 1) % 6);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at a falling edge, pass one rising edge, compare at the next falling edge
  task automatic step(input bit r, input bit e, input bit l, input logic [2:0] c,
                      input string req);
    logic [2:0] old;
    old = model;
    rst = r; en = e; load = l; load_code = c;
    @(posedge clk);
    @(negedge clk);
    if (r) model = 3'b000;
    else if (l) model = c;
    else if (e) model = model_next(model);
    check(count_q == model, req, count_q, model);
    check(unused == (model == 3'd3 || model == 3'd7), "R5", unused,
          (model == 3'd3 || model == 3'd7));
    if (!r && !l && e) begin
      if (old[1]) check(count_q[2] != old[2] && !count_q[0], "R7", count_q, model);
      if (old[0]) check(count_q[1] != old[1], "R8", count_q, model);
      else        check(!count_q[1], "R8", count_q, model);
      if (!(old == 3'd3 || old == 3'd7))
        check(!(count_q == 3'd3 || count_q == 3'd7), "R9", count_q, model);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R2: reset state
    step(1, 0, 0, 3'b000, "R2");
    // R1: two laps of the cycle
    for (int i = 0; i < 13; i++) step(0, 1, 0, 3'b000, "R1");
    // R3: hold with enable low
    for (int i = 0; i < 3; i++) step(0, 0, 0, 3'b000, "R3");
    // R4, R5, R6: load each unused code, then release
    step(0, 0, 1, 3'b011, "R4");
    step(0, 0, 0, 3'b000, "R3");
    step(0, 1, 0, 3'b000, "R6");
    check(count_q == 3'b100, "R6", count_q, 3'b100);
    step(0, 1, 1, 3'b111, "R4");
    step(0, 1, 0, 3'b000, "R6");
    check(count_q == 3'b000, "R6", count_q, 3'b000);
    // R4: load ignores enable, load wins over counting
    step(0, 1, 1, 3'b101, "R4");
    step(0, 0, 1, 3'b010, "R4");
    // R2: reset wins over load and enable
    step(1, 1, 1, 3'b110, "R2");
    check(count_q == 3'b000, "R2", count_q, 3'b000);
    // mixed stimulus for R1..R9
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[4:0] == 5'd0, lfsr[7:6] != 2'b00, lfsr[10:8] == 3'b000,
           lfsr[13:11], "R1");
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule